// File: doc/BRIEF.md
# Dual-Rate Byte SPI Master

This block is a byte-wide SPI master meant to sit in front of a memory-card socket. A processor drives it through two registers, one for data and one for control, using a single write strobe, a register select line and a combinational read path. A write to the data register, when no transfer is running, launches one 8-bit full-duplex exchange. The byte is shifted out MSB first on the output line while the incoming line is sampled into a receive register. When the transfer ends, the busy flag in the control register drops and the data register returns the byte that was received.

The control register holds a slave-select bit and a rate bit. The slave-select bit drives the active-low chip-select pin as its inverse, and only software changes it. The rate bit picks the serial clock period. In the default build the fast rate is 2 system clocks per SCK period, which gives 12.5 MHz from a 25 MHz clock. The slow rate is 64 system clocks per period, about 390 kHz, which stays below the 400 kHz ceiling that card initialisation needs. The block uses SPI mode 0. SCK rests low, and the output line rests high between transfers.

Top module: `sd_spi_master`

## Requirements
- R1: With `reg_sel`=0 (data register), a write while idle starts a transfer. The busy flag (control read bit 7) reads 1 from the next clock onward, for exactly 8×DIV clocks, where DIV is 2 (rate bit 0) or 64 (rate bit 1).
- R2: The transmitted byte appears on `spi_mosi` MSB first. Bit 7 is valid before the first rising SCK edge, and `spi_mosi` changes only together with a falling SCK edge during a transfer.
- R3: `spi_miso` is sampled at each rising SCK edge, MSB first. Once busy has cleared, a read with `reg_sel`=0 returns the received byte.
- R4: Control bit 1 is the rate bit. At 0, SCK is high for DIV/2=1 clock per bit. At 1, SCK is high for 32 clocks per bit. The rate in force is the one at the start of the transfer, and a change made mid-transfer applies from the next transfer.
- R5: Control bit 0 is the select bit. Writing 1 drives `spi_cs_n` low and writing 0 drives it high. `spi_cs_n` changes only after a control write, never because of a transfer.
- R6: A data-register write while busy is ignored. The byte shifted out and the transfer length stay those of the running transfer.
- R7: Outside a transfer, `spi_sck` is 0 and `spi_mosi` is 1.
- R8: After reset, `spi_cs_n`=1, both registers read 0, and the idle line levels of R7 hold.
- R9: A control read returns select at bit 0, rate at bit 1 and busy at bit 7, with the other bits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (25 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 data, 1 control |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
Every one of the 256 transmit bytes is sent at the fast rate, each paired with a different receive byte generated arithmetically. This separates bit-order faults, stuck lanes and swapped shift directions on both the outgoing and incoming paths. The all-zeros, all-ones and alternating patterns are repeated at the slow rate, where counting busy and SCK-high cycles tells the two dividers apart. Two extra scenarios cover mid-transfer activity: a data write landing during a transfer, which must not alter the outgoing byte or the length, and a rate change landing during a transfer, which must not alter the running transfer's timing. Chip select is watched on every cycle of every transfer, with select both asserted and released.

// File: rtl/sd_spi_pkg.sv
package sd_spi_pkg;
    typedef enum logic {
        REG_DATA = 1'b0,
        REG_CTRL = 1'b1
    } reg_sel_e;

    localparam int CTRL_SELECT_BIT = 0;
    localparam int CTRL_RATE_BIT   = 1;
endpackage

// File: rtl/sd_spi_clkgen.sv
module sd_spi_clkgen #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic slow_sel,
    input  logic run,
    output logic tick
);
    localparam int FAST_HALF = FAST_DIV / 2;
    localparam int SLOW_HALF = SLOW_DIV / 2;
    localparam int CW        = (SLOW_HALF > 1) ? $clog2(SLOW_HALF) : 1;
    localparam logic [CW-1:0] FAST_LOAD = CW'(FAST_HALF - 1);
    localparam logic [CW-1:0] SLOW_LOAD = CW'(SLOW_HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          slow;
    } gen_t;

    gen_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.slow = slow_sel;
            st_d.cnt  = slow_sel ? SLOW_LOAD : FAST_LOAD;
        end else if (run) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = st_q.slow ? SLOW_LOAD : FAST_LOAD;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = run && (st_q.cnt == '0);

    // R4
    rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> $stable(st_q.slow));

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.slow && run && !load) |-> (st_q.cnt <= FAST_LOAD));
endmodule

// File: rtl/sd_spi_shifter.sv
module sd_spi_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tick,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    typedef struct packed {
        logic              active;
        logic              sck;
        logic [BW-1:0]     bits;
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.active) begin
            if (start) begin
                st_d.active = 1'b1;
                st_d.sck    = 1'b0;
                st_d.bits   = '0;
                st_d.tx     = tx_byte;
            end
        end else if (tick) begin
            if (!st_q.sck) begin
                st_d.sck = 1'b1;
                st_d.rx  = {st_q.rx[DATA_W-2:0], miso};
            end else begin
                st_d.sck = 1'b0;
                if (st_q.bits == LAST_BIT) begin
                    st_d.active = 1'b0;
                end else begin
                    st_d.bits = st_q.bits + 1'b1;
                    st_d.tx   = {st_q.tx[DATA_W-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = st_q.active;
    assign sck     = st_q.sck;
    assign mosi    = st_q.active ? st_q.tx[DATA_W-1] : 1'b1;
    assign rx_byte = st_q.rx;

    // R7
    idle_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.active |-> !st_q.sck);

    // R2
    mosi_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && $past(st_q.active) && !$fell(st_q.sck)) |-> $stable(mosi));

    // R6
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && start && !tick) |=> (st_q.tx == $past(st_q.tx)));
endmodule

// File: rtl/sd_spi_ctrl.sv
module sd_spi_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              sel,
    input  logic [1:0]        wbits,
    input  logic              busy,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              slow,
    output logic              cs_n,
    output logic [DATA_W-1:0] rdata
);
    import sd_spi_pkg::*;

    typedef struct packed {
        logic select;
        logic rate;
    } ctl_t;

    ctl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr && (reg_sel_e'(sel) == REG_CTRL)) begin
            st_d.select = wbits[CTRL_SELECT_BIT];
            st_d.rate   = wbits[CTRL_RATE_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (reg_sel_e'(sel) == REG_CTRL) begin
            rdata[CTRL_SELECT_BIT] = st_q.select;
            rdata[CTRL_RATE_BIT]   = st_q.rate;
            rdata[DATA_W-1]        = busy;
        end else begin
            rdata = rx_byte;
        end
    end

    assign slow = st_q.rate;
    assign cs_n = ~st_q.select;

    // R5
    cs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cs_n) |-> $past(wr && (reg_sel_e'(sel) == REG_CTRL)));
endmodule

// File: rtl/sd_spi_master.sv
module sd_spi_master #(
    parameter int DATA_W   = 8,
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              spi_cs_n
);
    import sd_spi_pkg::*;

    logic              busy;
    logic              slow;
    logic              tick;
    logic              launch;
    logic              data_wr;
    logic [DATA_W-1:0] rx_byte;

    assign data_wr = reg_wr && (reg_sel_e'(reg_sel) == REG_DATA);
    assign launch  = data_wr && !busy;

    sd_spi_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .sel     (reg_sel),
        .wbits   (reg_wdata[1:0]),
        .busy    (busy),
        .rx_byte (rx_byte),
        .slow    (slow),
        .cs_n    (spi_cs_n),
        .rdata   (reg_rdata)
    );

    sd_spi_clkgen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .slow_sel (slow),
        .run      (busy),
        .tick     (tick)
    );

    sd_spi_shifter #(.DATA_W(DATA_W)) u_shifter (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (data_wr),
        .tx_byte (reg_wdata),
        .tick    (tick),
        .miso    (spi_miso),
        .busy    (busy),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .rx_byte (rx_byte)
    );

    // R1
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(launch));

    // R1
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> busy);
endmodule

// File: tb/sd_spi_master_test.sv
module sd_spi_master_test;
    localparam int CLK_PERIOD = 40;
    localparam int FAST_DIV   = 2;
    localparam int SLOW_DIV   = 64;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b1;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sck, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done   = 1'b0;

    logic [7:0] slv_sh;
    logic [7:0] cap;
    logic       cs_sel = 1'b0;
    logic       rate   = 1'b0;

    sd_spi_master uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .spi_sck   (spi_sck),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .spi_cs_n  (spi_cs_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // slave model: capture on rising SCK, present next bit on falling SCK
    always @(posedge spi_sck) cap = {cap[6:0], spi_mosi};
    always @(negedge spi_sck) begin
        slv_sh   = {slv_sh[6:0], 1'b0};
        spi_miso = slv_sh[7];
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic write_ctrl(input logic sel_bit, input logic rate_bit);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = {6'b0, rate_bit, sel_bit};
        @(negedge clk);
        reg_wr = 1'b0;
        cs_sel = sel_bit;
        rate   = rate_bit;
        #1;
        check(spi_cs_n == !sel_bit, "R5 cs_n after control write", spi_cs_n, !sel_bit);
        check(reg_rdata == {6'b0, rate_bit, sel_bit}, "R9 control readback",
              reg_rdata, {6'b0, rate_bit, sel_bit});
    endtask

    // mode: 0 plain, 1 data write mid-transfer, 2 rate flip mid-transfer
    task automatic xfer(input logic [7:0] tx, input logic [7:0] rx, input int mode);
        int div;
        int busy_n;
        int hi_n;
        bit cs_bad;
        div    = rate ? SLOW_DIV : FAST_DIV;
        busy_n = 0;
        hi_n   = 0;
        cs_bad = 1'b0;
        slv_sh   = rx;
        spi_miso = rx[7];
        cap      = '0;
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = tx;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b1;
        while (1) begin
            #1;
            if (!reg_rdata[7]) break;
            busy_n++;
            if (spi_sck) hi_n++;
            if (spi_cs_n != !cs_sel) cs_bad = 1'b1;
            if (busy_n == 3 && mode == 1) begin
                reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ~tx;
            end
            if (busy_n == 3 && mode == 2) begin
                reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = {6'b0, !rate, cs_sel};
            end
            @(negedge clk);
            reg_wr = 1'b0; reg_sel = 1'b1;
            if (busy_n > 4 * SLOW_DIV * 8) break;
        end
        if (mode == 2) rate = !rate;
        check(busy_n == 8 * div, "R1 busy length", busy_n, 8 * div);
        check(hi_n == 4 * div, "R4 SCK high clocks", hi_n, 4 * div);
        check(cap == tx, "R2 shifted-out byte", cap, tx);
        check(!cs_bad, "R5 cs_n untouched by transfer", cs_bad, 0);
        check(spi_sck == 1'b0 && spi_mosi == 1'b1, "R7 idle lines",
              {spi_sck, spi_mosi}, 2'b01);
        reg_sel = 1'b0;
        #1;
        check(reg_rdata == rx, "R3 received byte", reg_rdata, rx);
        reg_sel = 1'b1;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual %0d expected below %0d", cycles, WATCHDOG);
                summary();
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R8 reset state
        reg_sel = 1'b1;
        #1;
        check(reg_rdata == 8'h00, "R8 control after reset", reg_rdata, 0);
        reg_sel = 1'b0;
        #1;
        check(reg_rdata == 8'h00, "R8 data after reset", reg_rdata, 0);
        check(spi_cs_n == 1'b1, "R8 cs_n after reset", spi_cs_n, 1);
        check(spi_sck == 1'b0 && spi_mosi == 1'b1, "R8 idle lines after reset",
              {spi_sck, spi_mosi}, 2'b01);
        reg_sel = 1'b1;

        write_ctrl(1'b1, 1'b0);
        for (int i = 0; i < 256; i++) begin
            xfer(8'(i), 8'(i * 37 + 11), 0);
        end

        write_ctrl(1'b1, 1'b1);
        xfer(8'h00, 8'hFF, 0);
        xfer(8'hFF, 8'h00, 0);
        xfer(8'hA5, 8'h3C, 0);

        // R6 write while busy, slow and fast
        xfer(8'h96, 8'h69, 1);
        write_ctrl(1'b1, 1'b0);
        xfer(8'h5A, 8'hC3, 1);

        // R4 rate change mid-transfer applies to the next one
        xfer(8'h81, 8'h7E, 2);
        xfer(8'h18, 8'hE7, 0);

        // R5 released select stays high through a transfer
        write_ctrl(1'b0, 1'b0);
        xfer(8'h33, 8'hCC, 0);

        done = 1'b1;
        summary();
    end
endmodule